// File: doc/BRIEF.md
# Low-Resolution Chunky Pixel Fetcher

This block produces a low-resolution layer of 128×96 chunky pixels, drawn on a 256×192 display. Each layer pixel covers a 2×2 block of display pixels. For every valid display coordinate, the block works out the byte address of the layer data and issues a read. It then takes the returned byte and outputs an 8-bit palette index. When the layer is switched off, it outputs a transparent flag instead.

There are two colour depths. In the 8-bit depth, each pixel is one byte that is used directly as the palette index. The image is split across two halves of the memory window. In the 4-bit depth, each byte packs two pixels as nibbles. A 4-bit palette offset supplies the upper half of the index, and two control bits choose which half of the window holds the image.

The pipeline is fixed. The read goes out one clock after the coordinate. The memory answers one clock after the read. The index appears three clocks after the coordinate.

Top module: `lores_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, memRd, pixVldOut and pixTransparent are 0 and pixIdx is 0.
- R2: The layer pixel is (pixX>>1, pixY>>1), so all four display pixels of a 2×2 block produce the same read address.
- R3: With depthSel=0 and layer row ly below 48, the address is ly×128 + lx.
- R4: With depthSel=0 and layer row ly of 48 or more, the address is 0x2000 + (ly−48)×128 + lx.
- R5: With depthSel=0, pixIdx equals the byte returned by the memory.
- R6: With depthSel=1, the address is base + ly×64 + (lx>>1), where base is 0x0000 when bufSel XOR modeBit0 is 0.
- R7: With depthSel=1 and bufSel XOR modeBit0 equal to 1, base is 0x2000.
- R8: With depthSel=1, an even lx takes bits 7:4 of the byte and an odd lx takes bits 3:0.
- R9: With depthSel=1, pixIdx is {palOffset, nibble}, with palOffset in bits 7:4.
- R10: With layerEn=0, no read is issued. The output for that coordinate has pixTransparent=1 and pixIdx=0.
- R11: memRd and memAddr change one clock after pixValid is sampled. memData is taken one clock after memRd. pixVldOut, pixTransparent and pixIdx follow three clocks after pixValid. When pixVldOut is 0, pixIdx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | The display coordinate is valid this cycle |
| pixX | input | 8 | Display column, 0–255 |
| pixY | input | 8 | Display row, 0–191 |
| layerEn | input | 1 | Layer enable |
| depthSel | input | 1 | 0 = 8-bit pixels, 1 = 4-bit pixels |
| bufSel | input | 1 | Buffer choice for 4-bit pixels (XORed with modeBit0) |
| modeBit0 | input | 1 | Bit 0 of the display mode setting |
| palOffset | input | 4 | Upper palette bits for 4-bit pixels |
| memRd | output | 1 | Read strobe |
| memAddr | output | 14 | Byte offset into the layer window |
| memData | input | 8 | Read data, valid the clock after memRd |
| pixVldOut | output | 1 | Output pixel valid |
| pixTransparent | output | 1 | Layer off for this pixel |
| pixIdx | output | 8 | Palette index |

## Verification
The hardest condition to reach is a change of the control bits while pixels are in flight. Depth, offset, buffer and enable must each follow their own coordinate through the three stages, not the values present when the data returns. The stimulus changes depthSel, palOffset, bufSel, modeBit0 and layerEn on every cycle during a random phase. It also runs directed sweeps across rows 47/48 and the last row and column. The reference model tags each coordinate with its own controls, so a mixed-up stage shows up as a wrong index.

// File: rtl/lores_pkg.sv
package lores_pkg;

  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic issue;     // coordinate accepted and layer on: load address
    logic advance;   // coordinate accepted: load per-pixel metadata
    logic emitPix;   // stage 2 holds an enabled pixel
    logic emitBlank; // stage 2 holds a disabled pixel
  } loresStrobe_t;

  typedef enum logic {
    DEPTH8 = 1'b0,
    DEPTH4 = 1'b1
  } loresDepth_e;

  // Per-pixel metadata that travels beside the read
  typedef struct packed {
    loresDepth_e depth;
    logic        lowNib;
    logic [3:0]  offset;
  } loresMeta_t;

endpackage

// File: rtl/lores_ctrl.sv
module lores_ctrl
  import lores_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pixValid,
  input  logic         layerEn,
  output loresStrobe_t strb,
  output logic         memRd,
  output logic         pixVldOut,
  output logic         pixTransparent
);

  logic rdQ;
  logic vldS2, enS2;
  logic vldOutQ, transpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ     <= 1'b0;
      vldS2   <= 1'b0;
      enS2    <= 1'b0;
      vldOutQ <= 1'b0;
      transpQ <= 1'b0;
    end else begin
      rdQ     <= pixValid & layerEn;
      vldS2   <= vldS1;
      enS2    <= enS1;
      vldOutQ <= vldS2;
      transpQ <= vldS2 & ~enS2;
    end
  end

  logic vldS1, enS1;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldS1 <= 1'b0;
      enS1  <= 1'b0;
    end else begin
      vldS1 <= pixValid;
      enS1  <= layerEn;
    end
  end

  always_comb begin
    strb.issue     = pixValid & layerEn;
    strb.advance   = pixValid;
    strb.emitPix   = vldS2 & enS2;
    strb.emitBlank = vldS2 & ~enS2;
  end

  assign memRd          = rdQ;
  assign pixVldOut      = vldOutQ;
  assign pixTransparent = transpQ;

endmodule

// File: rtl/lores_dpath.sv
module lores_dpath
  import lores_pkg::*;
#(
  parameter int DISP_XW   = 8,
  parameter int DISP_YW   = 8,
  parameter int ADDR_W    = 14,
  parameter int LAYER_H   = 96,
  parameter int HALF_BASE = 8192
) (
  input  logic              clk,
  input  logic              rstN,
  input  loresStrobe_t      strb,
  input  logic [DISP_XW-1:0] pixX,
  input  logic [DISP_YW-1:0] pixY,
  input  logic              depthSel,
  input  logic              bufSel,
  input  logic              modeBit0,
  input  logic [3:0]        palOffset,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        pixIdx
);

  localparam int LX_W      = DISP_XW - 1;
  localparam int LY_W      = DISP_YW - 1;
  localparam int SPLIT_ROW = LAYER_H / 2;

  logic [LX_W-1:0]   layX;
  logic [LY_W-1:0]   layY;
  logic              upperHalf;
  logic [LY_W-1:0]   row8;
  logic [ADDR_W-1:0] addr8, addr4, base4, nextAddr;

  always_comb begin
    layX      = pixX[DISP_XW-1:1];
    layY      = pixY[DISP_YW-1:1];
    upperHalf = (int'(layY) >= SPLIT_ROW);
    row8      = upperHalf ? LY_W'(int'(layY) - SPLIT_ROW) : layY;
    addr8     = (upperHalf ? ADDR_W'(HALF_BASE) : '0)
              + (ADDR_W'(row8) << LX_W)
              + ADDR_W'(layX);
    base4     = (bufSel ^ modeBit0) ? ADDR_W'(HALF_BASE) : '0;
    addr4     = base4
              + (ADDR_W'(layY) << (LX_W - 1))
              + ADDR_W'(layX[LX_W-1:1]);
    nextAddr  = (loresDepth_e'(depthSel) == DEPTH4) ? addr4 : addr8;
  end

  loresMeta_t metaS1, metaS2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      metaS1  <= '0;
      metaS2  <= '0;
    end else begin
      if (strb.issue) memAddr <= nextAddr;
      if (strb.advance) begin
        metaS1.depth  <= loresDepth_e'(depthSel);
        metaS1.lowNib <= layX[0];
        metaS1.offset <= palOffset;
      end
      metaS2 <= metaS1;
    end
  end

  logic [3:0] nib;
  logic [7:0] idxNext;

  always_comb begin
    nib     = metaS2.lowNib ? memData[3:0] : memData[7:4];
    idxNext = (metaS2.depth == DEPTH4) ? {metaS2.offset, nib} : memData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pixIdx <= '0;
    else if (strb.emitPix) pixIdx <= idxNext;
    else                   pixIdx <= '0;
  end

endmodule

// File: rtl/lores_fetch.sv
module lores_fetch
  import lores_pkg::*;
#(
  parameter int DISP_XW   = 8,
  parameter int DISP_YW   = 8,
  parameter int ADDR_W    = 14,
  parameter int LAYER_H   = 96,
  parameter int HALF_BASE = 8192
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixValid,
  input  logic [DISP_XW-1:0] pixX,
  input  logic [DISP_YW-1:0] pixY,
  input  logic               layerEn,
  input  logic               depthSel,
  input  logic               bufSel,
  input  logic               modeBit0,
  input  logic [3:0]         palOffset,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [7:0]         memData,
  output logic               pixVldOut,
  output logic               pixTransparent,
  output logic [7:0]         pixIdx
);

  loresStrobe_t strb;

  lores_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .layerEn(layerEn),
    .strb(strb), .memRd(memRd), .pixVldOut(pixVldOut),
    .pixTransparent(pixTransparent)
  );

  lores_dpath #(
    .DISP_XW(DISP_XW), .DISP_YW(DISP_YW), .ADDR_W(ADDR_W),
    .LAYER_H(LAYER_H), .HALF_BASE(HALF_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .pixX(pixX), .pixY(pixY),
    .depthSel(depthSel), .bufSel(bufSel), .modeBit0(modeBit0),
    .palOffset(palOffset), .memData(memData), .memAddr(memAddr),
    .pixIdx(pixIdx)
  );

endmodule

// File: rtl/lores_fetch_chk.sv
module lores_fetch_chk #(
  parameter int ADDR_W  = 14,
  parameter int LAYER_H = 96,
  parameter int DISP_XW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pixValid,
  input logic              layerEn,
  input logic              depthSel,
  input logic [3:0]        palOffset,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pixVldOut,
  input logic              pixTransparent,
  input logic [7:0]        pixIdx
);
  localparam int HALF_SPAN = (LAYER_H / 2) << (DISP_XW - 1);

  // R10: a read only follows an enabled, valid coordinate
  p_read_needs_en_r10: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> $past(layerEn && pixValid));

  // R10: a transparent pixel never had a read two cycles before
  p_blank_no_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    pixTransparent |-> ($past(memRd, 2) == 1'b0));

  // R3 R4: 8-bit reads stay inside the populated part of each half
  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !$past(depthSel)) |-> (int'(memAddr[ADDR_W-2:0]) < HALF_SPAN));

  // R11: output valid three clocks after input valid
  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    pixVldOut |-> $past(pixValid, 3));

  // R9: 4-bit pixels carry the offset of their own coordinate
  p_offset_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pixVldOut && !pixTransparent && $past(depthSel, 3))
      |-> (pixIdx[7:4] == $past(palOffset, 3)));

  // R11: no index without a valid output
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !pixVldOut |-> (pixIdx == 8'h00));

endmodule

bind lores_fetch lores_fetch_chk #(
  .ADDR_W(ADDR_W), .LAYER_H(LAYER_H), .DISP_XW(DISP_XW)
) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .layerEn(layerEn),
  .depthSel(depthSel), .palOffset(palOffset), .memRd(memRd),
  .memAddr(memAddr), .pixVldOut(pixVldOut),
  .pixTransparent(pixTransparent), .pixIdx(pixIdx)
);

// File: tb/sim_lores_fetch.sv
`timescale 1ns/1ps
module sim_lores_fetch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0;
  logic [7:0] pixX = '0, pixY = '0;
  logic layerEn = 1'b0, depthSel = 1'b0, bufSel = 1'b0, modeBit0 = 1'b0;
  logic [3:0] palOffset = '0;
  logic memRd;
  logic [13:0] memAddr;
  logic [7:0] memData = '0;
  logic pixVldOut, pixTransparent;
  logic [7:0] pixIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lores_fetch u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixX(pixX), .pixY(pixY),
    .layerEn(layerEn), .depthSel(depthSel), .bufSel(bufSel),
    .modeBit0(modeBit0), .palOffset(palOffset), .memRd(memRd),
    .memAddr(memAddr), .memData(memData), .pixVldOut(pixVldOut),
    .pixTransparent(pixTransparent), .pixIdx(pixIdx)
  );

  function automatic logic [7:0] memf(int a);
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
  endfunction

  // memory: one clock of read latency
  always @(posedge clk) memData <= memf(int'(memAddr));

  typedef struct {
    bit vld; bit rd; int addr; bit transp; int idx;
    string tagA; string tagO;
  } expRec_t;

  expRec_t hist[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, int x, int y, bit en, bit ds, bit bs, bit mb,
                      int off, string tag);
    expRec_t r;
    int lx, ly, b, nib;
    @(negedge clk);
    if (hist.size() >= 1) begin
      chk({hist[0].tagA, " R11 rd"}, int'(memRd), int'(hist[0].rd));
      if (hist[0].rd) chk({hist[0].tagA, " addr"}, int'(memAddr), hist[0].addr);
    end
    if (hist.size() >= 3) begin
      chk({hist[2].tagO, " R11 vld"}, int'(pixVldOut), int'(hist[2].vld));
      chk({hist[2].tagO, " transp"}, int'(pixTransparent), int'(hist[2].transp));
      chk({hist[2].tagO, " idx"}, int'(pixIdx), hist[2].idx);
    end
    pixValid = v; pixX = 8'(x); pixY = 8'(y); layerEn = en; depthSel = ds;
    bufSel = bs; modeBit0 = mb; palOffset = 4'(off);
    lx = x / 2; ly = y / 2;
    r.vld = v && rstN; r.rd = 0; r.addr = 0; r.transp = 0; r.idx = 0;
    r.tagA = tag; r.tagO = tag;
    if (r.vld && !en) begin
      r.transp = 1; r.tagA = {tag, " R10"}; r.tagO = {tag, " R10"};
    end else if (r.vld) begin
      r.rd = 1;
      if (!ds) begin
        r.addr = (ly < 48) ? ly * 128 + lx : 8192 + (ly - 48) * 128 + lx;
        r.tagA = {tag, (ly < 48) ? " R3" : " R4"};
        r.idx = memf(r.addr); r.tagO = {tag, " R5"};
      end else begin
        r.addr = ((bs ^ mb) ? 8192 : 0) + ly * 64 + lx / 2;
        r.tagA = {tag, (bs ^ mb) ? " R7" : " R6"};
        b = memf(r.addr);
        nib = (lx % 2 == 1) ? b % 16 : b / 16;
        r.idx = off * 16 + nib; r.tagO = {tag, " R8 R9"};
      end
    end
    hist.push_front(r);
    if (hist.size() > 3) void'(hist.pop_back());
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset phase (R1)
    for (int i = 0; i < 4; i++) step(1, 10, 10, 1, 0, 0, 0, 3, "R1");
    chk("R1 rd", int'(memRd), 0);
    chk("R1 vld", int'(pixVldOut), 0);
    chk("R1 idx", int'(pixIdx), 0);
    @(negedge clk); rstN = 1'b1; hist.delete();
    chk("R1 transp", int'(pixTransparent), 0);
    // 8-bit sweeps across the split rows and edges
    for (int y = 92; y < 100; y++)
      for (int x = 0; x < 256; x += 17) step(1, x, y, 1, 0, 0, 0, 0, "sweep8");
    for (int x = 240; x < 256; x++) step(1, x, 191, 1, 0, 0, 0, 0, "edge8");
    // R2: 2x2 blocks share one address
    for (int x = 0; x < 8; x++) begin
      step(1, 40 + x, 20, 1, 0, 0, 0, 0, "R2");
      step(1, 40 + x, 21, 1, 1, 0, 0, 5, "R2");
    end
    // 4-bit, all buffer combinations and nibble sides
    for (int c = 0; c < 4; c++)
      for (int x = 0; x < 16; x++)
        step(1, 100 + x, 150 + c, 1, 1, c[0], c[1], c * 3 + 1, "buf4");
    // disabled layer and bubbles
    for (int i = 0; i < 20; i++) step(1, i * 9, i * 7, 0, i % 2, 0, 0, 7, "off");
    for (int i = 0; i < 10; i++) step(i % 3 == 0, i * 11, 190, i % 2, 0, 0, 0, 2, "gap");
    // random with controls changing every cycle
    for (int i = 0; i < 3000; i++)
      step($urandom % 5 != 0, $urandom % 256, $urandom % 192, $urandom % 4 != 0,
           $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 16, "rand");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "drain");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule